// File: doc/BRIEF.md
# PHY Register Handshake Master

This block lets on-chip logic read and write 16-bit registers held inside a PHY that exposes no memory-mapped access. Towards the PHY it owns one 20-bit control word and watches one 17-bit status word. Every step of a transfer is a four-phase exchange: the master raises one strobe, waits until the PHY raises its acknowledge, drops the strobe, and waits until the acknowledge falls again.

A user issues one request at a time: a read/write flag, a register address and, for a write, the data. The master first latches the address in the PHY. It then either moves the data across and commits it, or fetches the register contents. At the end it returns a one-cycle done pulse, the read data and an error flag. Each acknowledge wait samples a bounded number of times at a fixed spacing. If the PHY never answers, the transfer is abandoned and reported as failed.

Top module: `phy_reg_master`

## Requirements
- R1: Control word layout: bits 15:0 carry the address or the data; bit 16 captures the address, bit 17 captures the data, bit 18 commits a write and bit 19 starts a read. At most one of bits 19:16 is ever high.
- R2: Status word layout: bits 15:0 carry read data and bit 16 is the acknowledge.
- R3: Every transfer begins with this control sequence: the address alone, then the address with bit 16 until ack is 1, then the address alone until ack is 0.
- R4: A write continues with the data alone, then the data with bit 17 until ack is 1, then the data alone until ack is 0. Next comes bit 18 alone until ack is 1, then the data alone until ack is 0, and finally all zeros.
- R5: A read continues with bit 19 alone until ack is 1. The master stores status bits 15:0 as read data at that point, then drives all zeros until ack is 0.
- R6: Each acknowledge wait samples the registered ack once every SAMPLE_GAP cycles, at most MAX_SAMPLES times. An acknowledge that arrives inside that window lets the transfer go on.
- R7: If a wait runs out of samples, the transfer is abandoned. The control word goes to zero, done pulses with err high, and no further PHY step happens. For a write, this means the register is not written.
- R8: err reflects only the most recent transfer: a successful transfer ends with err low.
- R9: A request is taken only while busy is low. A request raised while busy is high has no effect.
- R10: busy rises the cycle after a request is accepted and falls in the cycle in which done pulses. done is high for exactly one cycle per transfer.
- R11: After reset, the control word is zero and busy, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Data from the last successful read |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Last transfer timed out |
| busy | output | 1 | Transfer in progress |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
A responder model with adjustable ack latency records every change of the control word, and the bench compares that record with the sequence expected for each read or write. A master that skipped a release phase, reordered the strobes or collapsed the address and data steps would leave a different record. The bench drives acknowledges that come late but still inside the sampling window, and acknowledges that come just outside it; a master with the wrong sample spacing or count would fail the first case or hang on the second. A PHY that never acknowledges and one whose ack sticks high exercise the abort path. A master that kept going after a timeout would corrupt the responder's registers, and one that left a strobe asserted would leave a nonzero control word. A request raised in the middle of a transfer must leave both the record and the register contents unchanged.

// File: rtl/phy_reg_pkg.sv
package phy_reg_pkg;

  localparam int STB_N = 4;

  // strobe nibble sits directly above the shared address/data field
  localparam logic [STB_N-1:0] STB_NONE = 4'b0000;
  localparam logic [STB_N-1:0] STB_CAPA = 4'b0001;
  localparam logic [STB_N-1:0] STB_CAPD = 4'b0010;
  localparam logic [STB_N-1:0] STB_WR   = 4'b0100;
  localparam logic [STB_N-1:0] STB_RD   = 4'b1000;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR_SET,
    S_ADDR_CAP,
    S_ADDR_REL,
    S_DATA_SET,
    S_DATA_CAP,
    S_DATA_REL,
    S_WR_STB,
    S_WR_REL,
    S_RD_STB,
    S_RD_REL
  } seq_state_e;

endpackage

// File: rtl/phy_ack_waiter.sv
module phy_ack_waiter #(
  parameter int SAMPLE_GAP  = 50,
  parameter int MAX_SAMPLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic want,
  input  logic ack,
  output logic hit,
  output logic expire
);

  localparam int GAP_W = $clog2(SAMPLE_GAP + 1);
  localparam int CNT_W = $clog2(MAX_SAMPLES + 1);

  logic             active;
  logic             want_q;
  logic [GAP_W-1:0] tick;
  logic [CNT_W-1:0] tries;
  logic             due;

  assign due    = active && (tick == '0);
  assign hit    = due && (ack == want_q);
  assign expire = due && (ack != want_q) && (tries == CNT_W'(MAX_SAMPLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      want_q <= 1'b0;
      tick   <= '0;
      tries  <= '0;
    end else if (arm) begin
      active <= 1'b1;
      want_q <= want;
      tick   <= '0;
      tries  <= '0;
    end else if (active) begin
      if (hit || expire) begin
        active <= 1'b0;
      end else if (tick == '0) begin
        tick  <= GAP_W'(SAMPLE_GAP - 1);
        tries <= tries + 1'b1;
      end else begin
        tick <= tick - 1'b1;
      end
    end
  end

  // R6: the sample count never exceeds its bound
  assert_tries_bound_R6: assert property (@(posedge clk) disable iff (rst)
    active |-> (tries < CNT_W'(MAX_SAMPLES)));

  // R6: a new wait is never started on top of a running one
  assert_no_rearm_R6: assert property (@(posedge clk) disable iff (rst)
    arm |-> !active);

endmodule

// File: rtl/phy_reg_seq.sv
module phy_reg_seq
  import phy_reg_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [FIELD_W-1:0]          req_addr,
  input  logic [FIELD_W-1:0]          req_wdata,
  input  logic [FIELD_W-1:0]          stat_data,
  input  logic                        hit,
  input  logic                        expire,
  output logic                        arm,
  output logic                        want,
  output logic [FIELD_W+STB_N-1:0]    ctrl,
  output logic [FIELD_W-1:0]          rdata,
  output logic                        done,
  output logic                        err,
  output logic                        busy
);

  localparam int CTRL_W = FIELD_W + STB_N;

  seq_state_e          state;
  logic [FIELD_W-1:0]  addr_q;
  logic [FIELD_W-1:0]  data_q;
  logic                wr_q;
  logic [CTRL_W-1:0]   ctrl_q;
  logic                arm_q;
  logic                want_q;
  logic [FIELD_W-1:0]  rdata_q;
  logic                done_q;
  logic                err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      wr_q    <= 1'b0;
      ctrl_q  <= '0;
      arm_q   <= 1'b0;
      want_q  <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      arm_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          data_q <= req_wdata;
          wr_q   <= req_write;
          err_q  <= 1'b0;
          ctrl_q <= {STB_NONE, req_addr};
          state  <= S_ADDR_SET;
        end
        S_ADDR_SET: begin
          ctrl_q <= {STB_CAPA, addr_q};
          arm_q  <= 1'b1;
          want_q <= 1'b1;
          state  <= S_ADDR_CAP;
        end
        S_ADDR_CAP: if (hit) begin
          ctrl_q <= {STB_NONE, addr_q};
          arm_q  <= 1'b1;
          want_q <= 1'b0;
          state  <= S_ADDR_REL;
        end
        S_ADDR_REL: if (hit) begin
          if (wr_q) begin
            ctrl_q <= {STB_NONE, data_q};
            state  <= S_DATA_SET;
          end else begin
            ctrl_q <= {STB_RD, {FIELD_W{1'b0}}};
            arm_q  <= 1'b1;
            want_q <= 1'b1;
            state  <= S_RD_STB;
          end
        end
        S_DATA_SET: begin
          ctrl_q <= {STB_CAPD, data_q};
          arm_q  <= 1'b1;
          want_q <= 1'b1;
          state  <= S_DATA_CAP;
        end
        S_DATA_CAP: if (hit) begin
          ctrl_q <= {STB_NONE, data_q};
          arm_q  <= 1'b1;
          want_q <= 1'b0;
          state  <= S_DATA_REL;
        end
        S_DATA_REL: if (hit) begin
          ctrl_q <= {STB_WR, {FIELD_W{1'b0}}};
          arm_q  <= 1'b1;
          want_q <= 1'b1;
          state  <= S_WR_STB;
        end
        S_WR_STB: if (hit) begin
          ctrl_q <= {STB_NONE, data_q};
          arm_q  <= 1'b1;
          want_q <= 1'b0;
          state  <= S_WR_REL;
        end
        S_WR_REL: if (hit) begin
          ctrl_q <= '0;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        S_RD_STB: if (hit) begin
          rdata_q <= stat_data;
          ctrl_q  <= '0;
          arm_q   <= 1'b1;
          want_q  <= 1'b0;
          state   <= S_RD_REL;
        end
        S_RD_REL: if (hit) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      // R7: an exhausted wait overrides whatever step was pending
      if (expire) begin
        ctrl_q <= '0;
        arm_q  <= 1'b0;
        done_q <= 1'b1;
        err_q  <= 1'b1;
        state  <= S_IDLE;
      end
    end
  end

  assign ctrl  = ctrl_q;
  assign arm   = arm_q;
  assign want  = want_q;
  assign rdata = rdata_q;
  assign done  = done_q;
  assign err   = err_q;
  assign busy  = (state != S_IDLE);

  // R1: never more than one strobe at a time
  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl_q[CTRL_W-1 -: STB_N]));

  // R7: an idle master leaves the PHY with an all-zero control word
  assert_idle_ctrl_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> (ctrl_q == '0));

  // R9: a transfer only starts in response to a request
  assert_accept_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R10: done is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R4: the write commit strobe is only raised after the data release wait
  assert_wr_after_data_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q[FIELD_W+2]) |-> $past(state == S_DATA_REL));

endmodule

// File: rtl/phy_reg_master.sv
module phy_reg_master #(
  parameter int FIELD_W     = 16,
  parameter int SAMPLE_GAP  = 50,
  parameter int MAX_SAMPLES = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [FIELD_W-1:0]   req_addr,
  input  logic [FIELD_W-1:0]   req_wdata,
  output logic [FIELD_W-1:0]   rd_data,
  output logic                 done,
  output logic                 err,
  output logic                 busy,
  output logic [FIELD_W+3:0]   phy_ctrl,
  input  logic [FIELD_W:0]     phy_stat
);

  localparam int STAT_W = FIELD_W + 1;

  logic [STAT_W-1:0] stat_q;
  logic              arm, want, hit, expire;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= phy_stat;
  end

  phy_ack_waiter #(
    .SAMPLE_GAP (SAMPLE_GAP),
    .MAX_SAMPLES(MAX_SAMPLES)
  ) u_wait (
    .clk   (clk),
    .rst   (rst),
    .arm   (arm),
    .want  (want),
    .ack   (stat_q[FIELD_W]),
    .hit   (hit),
    .expire(expire)
  );

  phy_reg_seq #(
    .FIELD_W(FIELD_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .stat_data(stat_q[FIELD_W-1:0]),
    .hit      (hit),
    .expire   (expire),
    .arm      (arm),
    .want     (want),
    .ctrl     (phy_ctrl),
    .rdata    (rd_data),
    .done     (done),
    .err      (err),
    .busy     (busy)
  );

  // R10: busy and done are never high together
  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: a completed wait and a timeout never coincide
  assert_hit_expire_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(hit && expire));

endmodule

// File: tb/tb_phy_reg_master.sv
module tb_phy_reg_master;

  localparam int FW  = 16;
  localparam int GAP = 50;
  localparam int MS  = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [FW-1:0] req_addr  = '0;
  logic [FW-1:0] req_wdata = '0;
  logic [FW-1:0] rd_data;
  logic          done, err, busy;
  logic [FW+3:0] phy_ctrl;
  logic [FW:0]   phy_stat;

  always #10 clk = ~clk;

  phy_reg_master #(.FIELD_W(FW), .SAMPLE_GAP(GAP), .MAX_SAMPLES(MS)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .done(done), .err(err), .busy(busy), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat));

  int errors = 0;
  int checks = 0;

  // ---------------- PHY responder model ----------------
  logic [15:0] pmem [256];
  logic [15:0] shadow [256];
  logic        ack_r = 1'b0;
  logic [15:0] pdata = '0;
  logic [15:0] addr_l = '0, data_l = '0;
  int          lat = 1;
  int          wcnt = 0;
  bit          mode_dead = 0, mode_stuck = 0;

  assign phy_stat = {ack_r, pdata};

  always @(posedge clk) begin
    logic tgt;
    tgt = |phy_ctrl[19:16];
    if (mode_dead) tgt = 1'b0;
    if (mode_stuck && ack_r) tgt = 1'b1;
    if (ack_r != tgt) begin
      if (wcnt >= lat) begin
        ack_r <= tgt;
        wcnt  <= 0;
        if (tgt) begin
          if (phy_ctrl[16]) addr_l <= phy_ctrl[15:0];
          if (phy_ctrl[17]) data_l <= phy_ctrl[15:0];
          if (phy_ctrl[18]) pmem[addr_l[7:0]] <= data_l;
          if (phy_ctrl[19]) pdata <= pmem[addr_l[7:0]];
        end
      end else wcnt <= wcnt + 1;
    end else wcnt <= 0;
  end

  // ---------------- control word change log ----------------
  logic [19:0] clog [32];
  int          clog_n = 0;
  logic [19:0] cprev = '0;
  always @(negedge clk) begin
    if (phy_ctrl !== cprev) begin
      if (clog_n < 32) clog[clog_n] = phy_ctrl;
      clog_n = clog_n + 1;
      cprev  = phy_ctrl;
    end
  end

  logic [19:0] elog [16];
  int          elog_n;

  task automatic exp_push(input logic [19:0] v, inout logic [19:0] prev);
    if (v != prev) begin
      elog[elog_n] = v;
      elog_n = elog_n + 1;
      prev = v;
    end
  endtask

  task automatic build_expected(input bit wr, input logic [15:0] a, input logic [15:0] d);
    logic [19:0] p;
    p = '0;
    elog_n = 0;
    exp_push({4'b0000, a}, p);
    exp_push({4'b0001, a}, p);
    exp_push({4'b0000, a}, p);
    if (wr) begin
      exp_push({4'b0000, d}, p);
      exp_push({4'b0010, d}, p);
      exp_push({4'b0000, d}, p);
      exp_push({4'b0100, 16'h0}, p);
      exp_push({4'b0000, d}, p);
      exp_push(20'h0, p);
    end else begin
      exp_push({4'b1000, 16'h0}, p);
      exp_push(20'h0, p);
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_log(input string req);
    bit ok;
    ok = (clog_n == elog_n);
    for (int i = 0; i < elog_n && i < 32; i++) if (clog[i] !== elog[i]) ok = 0;
    chk(ok, req, "control sequence", 32'(clog_n), 32'(elog_n));
    if (!ok)
      for (int i = 0; i < elog_n; i++)
        $display("  step %0d got %h want %h", i, (i < clog_n) ? clog[i] : 20'hx, elog[i]);
  endtask

  logic [15:0] last_rd;
  logic        last_err;
  int          last_cyc;

  task automatic start_txn(input bit wr, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    clog_n = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    last_cyc = 1;
    chk(busy === 1'b1, "R10", "busy after accept", 32'(busy), 32'd1);
  endtask

  task automatic wait_done();
    while (done !== 1'b1 && last_cyc < 20000) begin
      @(negedge clk);
      last_cyc++;
    end
    last_rd  = rd_data;
    last_err = err;
    chk(done === 1'b1, "R10", "done seen", 32'(done), 32'd1);
    chk(busy === 1'b0, "R10", "busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done one cycle", 32'(done), 32'd0);
  endtask

  task automatic txn(input bit wr, input logic [15:0] a, input logic [15:0] d);
    start_txn(wr, a, d);
    wait_done();
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      pmem[i]   = 16'(i * 16'h0101 ^ 16'h5a5a);
      shadow[i] = pmem[i];
    end
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(phy_ctrl === '0, "R11", "ctrl in reset", 32'(phy_ctrl), 32'd0);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R11", "flags in reset",
        {busy, done, err}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(phy_ctrl === '0 && busy === 1'b0, "R11", "idle after reset", 32'(phy_ctrl), 32'd0);

    // directed: write then read at corner addresses and data
    begin
      logic [15:0] av [4] = '{16'h0000, 16'h00ff, 16'h0012, 16'h0034};
      logic [15:0] dv [4] = '{16'hffff, 16'h0000, 16'h0012, 16'ha5c3};
      for (int k = 0; k < 4; k++) begin
        lat = 1;
        txn(1'b1, av[k], dv[k]);
        shadow[av[k][7:0]] = dv[k];
        build_expected(1'b1, av[k], dv[k]);
        check_log("R3 R4");
        chk(last_err === 1'b0, "R8", "write err", 32'(last_err), 32'd0);
        chk(phy_ctrl === '0, "R4", "ctrl zero after write", 32'(phy_ctrl), 32'd0);
        chk(pmem[av[k][7:0]] === dv[k], "R4", "PHY register written", 32'(pmem[av[k][7:0]]), 32'(dv[k]));
        txn(1'b0, av[k], 16'h0);
        build_expected(1'b0, av[k], 16'h0);
        check_log("R3 R5");
        chk(last_rd === dv[k], "R5 R2", "read data", 32'(last_rd), 32'(dv[k]));
      end
    end

    // random mix with varied ack latency
    for (int n = 0; n < 30; n++) begin
      bit          wr;
      logic [15:0] a, d;
      wr  = 1'($urandom_range(0, 1));
      a   = 16'($urandom_range(0, 255));
      d   = 16'($urandom);
      lat = $urandom_range(0, 6);
      txn(wr, a, d);
      build_expected(wr, a, d);
      check_log(wr ? "R4" : "R5");
      if (wr) shadow[a[7:0]] = d;
      else chk(last_rd === shadow[a[7:0]], "R5", "random read", 32'(last_rd), 32'(shadow[a[7:0]]));
      chk(last_err === 1'b0, "R8", "random err", 32'(last_err), 32'd0);
    end

    // R9: request during busy is ignored
    lat = 2;
    start_txn(1'b1, 16'h0040, 16'h1357);
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0041; req_wdata = 16'hdead;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    shadow[8'h40] = 16'h1357;
    build_expected(1'b1, 16'h0040, 16'h1357);
    check_log("R9");
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && phy_ctrl === '0, "R9", "no second transfer", 32'(busy), 32'd0);
    chk(pmem[8'h41] === shadow[8'h41], "R9", "ignored write target", 32'(pmem[8'h41]), 32'(shadow[8'h41]));

    // R6: slow ack inside the sampling window succeeds
    lat = 380;
    txn(1'b1, 16'h0077, 16'hbeef);
    shadow[8'h77] = 16'hbeef;
    chk(last_err === 1'b0, "R6", "slow ack accepted", 32'(last_err), 32'd0);
    chk(pmem[8'h77] === 16'hbeef, "R6", "slow write landed", 32'(pmem[8'h77]), 32'hbeef);

    // R6 R7: ack beyond the window fails
    lat = 520;
    txn(1'b1, 16'h0078, 16'h4444);
    chk(last_err === 1'b1, "R6", "late ack times out", 32'(last_err), 32'd1);
    chk(phy_ctrl === '0, "R7", "ctrl zero after timeout", 32'(phy_ctrl), 32'd0);

    // R7: dead PHY, write aborted, timing bounded by samples*gap
    lat = 1;
    mode_dead = 1;
    txn(1'b1, 16'h0079, 16'h9999);
    chk(last_err === 1'b1, "R7", "dead PHY err", 32'(last_err), 32'd1);
    chk(last_cyc >= (MS - 1) * GAP && last_cyc <= MS * GAP + 20, "R6",
        "timeout latency", 32'(last_cyc), 32'(MS * GAP));
    chk(phy_ctrl === '0, "R7", "ctrl zero dead", 32'(phy_ctrl), 32'd0);
    mode_dead = 0;
    repeat (5) @(negedge clk);
    chk(pmem[8'h79] === shadow[8'h79], "R7", "aborted write not stored", 32'(pmem[8'h79]), 32'(shadow[8'h79]));

    // R7: ack stuck high, release wait times out
    mode_stuck = 1;
    txn(1'b0, 16'h0012, 16'h0);
    chk(last_err === 1'b1, "R7", "stuck ack err", 32'(last_err), 32'd1);
    chk(phy_ctrl === '0, "R7", "ctrl zero stuck", 32'(phy_ctrl), 32'd0);
    mode_stuck = 0;
    repeat (10) @(negedge clk);

    // R8: next good transfer clears err
    txn(1'b0, 16'h0077, 16'h0);
    chk(last_err === 1'b0, "R8", "err cleared", 32'(last_err), 32'd0);
    chk(last_rd === 16'hbeef, "R5", "read after recovery", 32'(last_rd), 32'hbeef);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule